// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers interrupt events for a packet interface bridge. Five single-cycle event pulses from the data path are latched into a sticky flag register. Each flag stays set until software clears it. A matching enable register masks the flags. The block also captures a 6-bit per-channel event code into a second status register, which has its own enable mask.

A small synchronous register port gives software read and write access to the four registers. The flag register is cleared bit by bit, by writing ones. The event-code register is cleared as a whole, and only by an acknowledge write of exactly 0xFF. A single interrupt output is high whenever either group has an enabled, pending cause.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, all four registers and `irq_o` are zero.
- R2: An event pulse sets a flag bit on the next clock edge, and the bit then stays set. The bit positions are:
  - bit 0: trunk-side ingress drop
  - bit 1: tributary-side ingress drop
  - bit 2: tributary ingress clock loss
  - bit 3: tributary egress clock loss
  - bit 4: tributary buffer flush
- R3: Flag bit 4 is set by either `flush_parity_i` or `flush_nobuf_i`.
- R4: A write to flag offset 0x0C clears each flag bit that is written as 1. A bit written as 0 is left unchanged.
- R5: If an event and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R6: The flag enable register at offset 0x0D is a 5-bit read/write register in bits 4:0. The flag group asserts an interrupt when any flag bit and its enable bit are both 1.
- R7: The event-code register at offset 0x0E loads `code_i` on `code_valid_i` only while it holds zero. While it is nonzero, it keeps the first code it loaded.
- R8: The event-code register is cleared only by a write of exactly 0x000000FF to offset 0x0E. Any other write to that offset has no effect.
- R9: The code enable register at offset 0x0F is a 6-bit read/write register in bits 5:0. The code group asserts an interrupt when the bitwise AND of the code and this mask is nonzero. `irq_o` is the OR of the flag group and the code group.
- R10: Register addresses are `BASE` plus the offset, with a default `BASE` of 0x0C00. Read data appears on `rd_data_o` one cycle after `rd_en_i`. Reserved bits and unmapped addresses read as zero, and `rd_data_o` is zero in any cycle that follows a cycle without a read.
- R11: If an acknowledge write and `code_valid_i` occur in the same cycle, the event-code register takes the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drop_trunk_i | input | 1 | Pulse: trunk-side ingress data dropped |
| drop_trib_i | input | 1 | Pulse: tributary-side ingress data dropped |
| trib_in_clk_fail_i | input | 1 | Pulse: tributary ingress clock lost |
| trib_out_clk_fail_i | input | 1 | Pulse: tributary egress clock lost |
| flush_parity_i | input | 1 | Pulse: buffer flushed after an address parity error |
| flush_nobuf_i | input | 1 | Pulse: buffer flushed because no ingress buffer was free |
| code_valid_i | input | 1 | Event code present on `code_i` |
| code_i | input | 6 | Per-channel event code |
| addr_i | input | 16 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Combined interrupt |

## Verification
If the flag register holds a wrong value, the error shows at the ports within one cycle. It appears either on `irq_o`, once the enable is set, or on the next read of offset 0x0C. A lost set-over-clear priority, for example, shows as a zero read right after the same-cycle collision.

An event-code register that reloads while it is nonzero, or that clears on the wrong acknowledge value, produces a wrong read at 0x0E on the following cycle. The bench compares `irq_o` and `rd_data_o` against a behavioural model on every clock, so a divergence is reported in the cycle where it first becomes visible.

// File: rtl/irq_pkg.sv
// Shared constants for the sticky interrupt status controller.
// Assumes a word-addressed register port; offsets are added to a base.
package irq_pkg;
    localparam int FLAG_W   = 5;
    localparam int CODE_W   = 6;
    localparam int OFF_FLAG = 'h0C;
    localparam int OFF_FEN  = 'h0D;
    localparam int OFF_CODE = 'h0E;
    localparam int OFF_CEN  = 'h0F;
    localparam int ACK_WORD = 'hFF;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_FLAG = 3'd1,
        SEL_FEN  = 3'd2,
        SEL_CODE = 3'd3,
        SEL_CEN  = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
// Register port decode and registered read mux.
// Assumes single-cycle strobes; reads return data one cycle later, zero otherwise.
module irq_reg_decode #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 16'h0C00
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        wr_en_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    input  logic                        rd_en_i,
    input  logic [irq_pkg::FLAG_W-1:0]  flags_i,
    input  logic [irq_pkg::FLAG_W-1:0]  fen_i,
    input  logic [irq_pkg::CODE_W-1:0]  code_i,
    input  logic [irq_pkg::CODE_W-1:0]  cen_i,
    output logic [irq_pkg::FLAG_W-1:0]  flag_clr_o,
    output logic                        fen_we_o,
    output logic                        cen_we_o,
    output logic                        code_ack_o,
    output logic [DATA_W-1:0]           rd_data_o
);
    import irq_pkg::*;

    localparam logic [ADDR_W-1:0] A_FLAG = BASE + ADDR_W'(OFF_FLAG);
    localparam logic [ADDR_W-1:0] A_FEN  = BASE + ADDR_W'(OFF_FEN);
    localparam logic [ADDR_W-1:0] A_CODE = BASE + ADDR_W'(OFF_CODE);
    localparam logic [ADDR_W-1:0] A_CEN  = BASE + ADDR_W'(OFF_CEN);
    localparam logic [DATA_W-1:0] ACK_V  = DATA_W'(ACK_WORD);

    reg_sel_e           sel;
    logic [DATA_W-1:0]  rd_next;

    // Map the address to one of the four registers.
    always_comb begin
        unique case (addr_i)
            A_FLAG:  sel = SEL_FLAG;
            A_FEN:   sel = SEL_FEN;
            A_CODE:  sel = SEL_CODE;
            A_CEN:   sel = SEL_CEN;
            default: sel = SEL_NONE;
        endcase
    end

    // Write strobes per register.
    always_comb begin
        flag_clr_o = (wr_en_i && sel == SEL_FLAG) ? wr_data_i[FLAG_W-1:0] : '0;
        fen_we_o   = wr_en_i && sel == SEL_FEN;
        cen_we_o   = wr_en_i && sel == SEL_CEN;
        code_ack_o = wr_en_i && sel == SEL_CODE && wr_data_i == ACK_V;
    end

    // Read mux, zero-extended; reserved bits and unmapped addresses read zero.
    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_FLAG: rd_next[FLAG_W-1:0] = flags_i;
            SEL_FEN:  rd_next[FLAG_W-1:0] = fen_i;
            SEL_CODE: rd_next[CODE_W-1:0] = code_i;
            SEL_CEN:  rd_next[CODE_W-1:0] = cen_i;
            default:  rd_next = '0;
        endcase
    end

    // Registered read data; zero whenever there is no read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= rd_next;
        else              rd_data_o <= '0;
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Sticky single-bit flags with write-one-to-clear and an enable mask.
// Assumes event pulses are synchronous to clk; a set wins over a clear.
module irq_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         en_we_i,
    input  logic [N-1:0] en_wdata_i,
    output logic [N-1:0] flags_o,
    output logic [N-1:0] en_o,
    output logic         irq_o
);
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_flag
            // One sticky flag: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)          flags_o[gi] <= 1'b0;
                else if (set_i[gi])  flags_o[gi] <= 1'b1;
                else if (clr_i[gi])  flags_o[gi] <= 1'b0;
            end
        end
    endgenerate

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_o <= '0;
        else if (en_we_i) en_o <= en_wdata_i;
    end

    // Group interrupt from enabled pending flags.
    assign irq_o = |(flags_o & en_o);
endmodule

// File: rtl/irq_code_latch.sv
// Event-code capture register with a whole-word acknowledge and an enable mask.
// Assumes the first nonzero code is kept until acknowledged; capture beats ack.
module irq_code_latch #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [W-1:0] code_i,
    input  logic         ack_i,
    input  logic         en_we_i,
    input  logic [W-1:0] en_wdata_i,
    output logic [W-1:0] code_o,
    output logic [W-1:0] en_o,
    output logic         irq_o
);
    logic empty;
    assign empty = (code_o == '0);

    // Capture only while empty; an acknowledge empties it unless a code arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                      code_o <= '0;
        else if (ack_i)                  code_o <= valid_i ? code_i : '0;
        else if (empty && valid_i)       code_o <= code_i;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_o <= '0;
        else if (en_we_i) en_o <= en_wdata_i;
    end

    // Group interrupt when any enabled code bit is set.
    assign irq_o = |(code_o & en_o);
endmodule

// File: rtl/irq_status_ctrl.sv
// Top of the sticky interrupt status controller: flag bank, code latch, port decode.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module irq_status_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 16'h0C00
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        drop_trunk_i,
    input  logic                        drop_trib_i,
    input  logic                        trib_in_clk_fail_i,
    input  logic                        trib_out_clk_fail_i,
    input  logic                        flush_parity_i,
    input  logic                        flush_nobuf_i,
    input  logic                        code_valid_i,
    input  logic [irq_pkg::CODE_W-1:0]  code_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        wr_en_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    input  logic                        rd_en_i,
    output logic [DATA_W-1:0]           rd_data_o,
    output logic                        irq_o
);
    import irq_pkg::*;

    logic [FLAG_W-1:0] ev_vec;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] fen_q;
    logic [FLAG_W-1:0] flag_clr;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] cen_q;
    logic              fen_we;
    logic              cen_we;
    logic              code_ack;
    logic              flag_irq;
    logic              code_irq;

    // Event vector in flag bit order; both flush causes share bit 4.
    assign ev_vec = {flush_parity_i | flush_nobuf_i, trib_out_clk_fail_i,
                     trib_in_clk_fail_i, drop_trib_i, drop_trunk_i};

    irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .flags_i(flags_q),
        .fen_i(fen_q), .code_i(code_q), .cen_i(cen_q), .flag_clr_o(flag_clr),
        .fen_we_o(fen_we), .cen_we_o(cen_we), .code_ack_o(code_ack),
        .rd_data_o(rd_data_o)
    );

    irq_flag_bank #(.N(FLAG_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(ev_vec), .clr_i(flag_clr),
        .en_we_i(fen_we), .en_wdata_i(wr_data_i[FLAG_W-1:0]),
        .flags_o(flags_q), .en_o(fen_q), .irq_o(flag_irq)
    );

    irq_code_latch #(.W(CODE_W)) u_code (
        .clk(clk), .rst_n(rst_n), .valid_i(code_valid_i), .code_i(code_i),
        .ack_i(code_ack), .en_we_i(cen_we), .en_wdata_i(wr_data_i[CODE_W-1:0]),
        .code_o(code_q), .en_o(cen_q), .irq_o(code_irq)
    );

    // Combined interrupt output.
    assign irq_o = flag_irq | code_irq;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
// Assertion checker for irq_status_ctrl, bound to every instance of the top.
// Assumes synchronous active-low reset; all properties are disabled during reset.
module irq_status_ctrl_chk #(
    parameter int FLAG_W = 5,
    parameter int CODE_W = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FLAG_W-1:0] ev_vec,
    input logic [FLAG_W-1:0] flags_q,
    input logic [FLAG_W-1:0] flag_clr,
    input logic [CODE_W-1:0] code_q,
    input logic              code_ack,
    input logic              code_valid_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              irq_o
);
    assert_set_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vec != '0) |=> ((flags_q & $past(ev_vec)) == $past(ev_vec)));

    assert_w1c_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vec == '0) |=> (flags_q == ($past(flags_q) & ~$past(flag_clr))));

    assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != '0 && !code_ack) |=> (code_q == $past(code_q)));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_ack && !code_valid_i) |=> (code_q == '0));

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q == '0 && code_q == '0) |-> !irq_o);

    assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rd_data_o == '0));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
    .FLAG_W(irq_pkg::FLAG_W), .CODE_W(irq_pkg::CODE_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec), .flags_q(flags_q),
    .flag_clr(flag_clr), .code_q(code_q), .code_ack(code_ack),
    .code_valid_i(code_valid_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
    localparam logic [15:0] BASE = 16'h0C00;
    localparam logic [15:0] A_FLAG = BASE + 16'h0C;
    localparam logic [15:0] A_FEN  = BASE + 16'h0D;
    localparam logic [15:0] A_CODE = BASE + 16'h0E;
    localparam logic [15:0] A_CEN  = BASE + 16'h0F;

    logic clk = 0;
    logic rst_n = 0;
    logic drop_trunk = 0, drop_trib = 0, in_fail = 0, out_fail = 0;
    logic fl_par = 0, fl_nobuf = 0;
    logic code_valid = 0;
    logic [5:0] code = 0;
    logic [15:0] addr = 0;
    logic wr_en = 0, rd_en = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic irq;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_status_ctrl i_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .drop_trunk_i(drop_trunk), .drop_trib_i(drop_trib),
        .trib_in_clk_fail_i(in_fail), .trib_out_clk_fail_i(out_fail),
        .flush_parity_i(fl_par), .flush_nobuf_i(fl_nobuf),
        .code_valid_i(code_valid), .code_i(code), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated at each rising edge.
    logic [4:0] m_flags, m_fen;
    logic [5:0] m_code, m_cen;
    logic [31:0] m_rd;
    always @(posedge clk) begin
        logic [4:0] evs;
        logic [4:0] clrs;
        logic [31:0] look;
        if (!rst_n) begin
            m_flags = 0; m_fen = 0; m_code = 0; m_cen = 0; m_rd = 0;
        end else begin
            evs = {fl_par | fl_nobuf, out_fail, in_fail, drop_trib, drop_trunk};
            clrs = (wr_en && addr == A_FLAG) ? wr_data[4:0] : 5'd0;
            case (addr)
                A_FLAG:  look = {27'd0, m_flags};
                A_FEN:   look = {27'd0, m_fen};
                A_CODE:  look = {26'd0, m_code};
                A_CEN:   look = {26'd0, m_cen};
                default: look = 0;
            endcase
            m_rd = rd_en ? look : 32'd0;
            m_flags = (m_flags & ~clrs) | evs;
            if (wr_en && addr == A_FEN) m_fen = wr_data[4:0];
            if (wr_en && addr == A_CEN) m_cen = wr_data[5:0];
            if (wr_en && addr == A_CODE && wr_data == 32'hFF)
                m_code = code_valid ? code : 6'd0;
            else if (m_code == 0 && code_valid)
                m_code = code;
        end
    end

    // Per-cycle comparison against the model (R9 interrupt, R10 read data).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq_o vs model", {31'd0, irq}, {31'd0, (|(m_flags & m_fen)) | (|(m_code & m_cen))});
            chk("R10 rd_data_o vs model", rd_data, m_rd);
        end
    end

    task automatic ev(input logic [5:0] e);
        @(negedge clk);
        {fl_nobuf, fl_par, out_fail, in_fail, drop_trib, drop_trunk} = e;
        @(negedge clk);
        {fl_nobuf, fl_par, out_fail, in_fail, drop_trib, drop_trunk} = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        chk(tag, rd_data, exp);
    endtask

    task automatic cpulse(input logic [5:0] c);
        @(negedge clk);
        code = c; code_valid = 1;
        @(negedge clk);
        code_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        rd(A_FLAG, 0, "R1 flags reset");
        rd(A_FEN, 0, "R1 flag enable reset");
        rd(A_CODE, 0, "R1 code reset");
        rd(A_CEN, 0, "R1 code enable reset");
        // R2: setting and stickiness
        ev(6'b000001);
        rd(A_FLAG, 32'h01, "R2 trunk drop bit0");
        ev(6'b001100);
        rd(A_FLAG, 32'h0D, "R2 clock loss bits 2,3 sticky");
        // R3: both flush causes
        ev(6'b010000);
        rd(A_FLAG, 32'h1D, "R3 parity flush bit4");
        wr(A_FLAG, 32'h10);
        rd(A_FLAG, 32'h0D, "R4 clear bit4");
        ev(6'b100000);
        rd(A_FLAG, 32'h1D, "R3 no-buffer flush bit4");
        // R4: write-one-to-clear
        wr(A_FLAG, 32'h0);
        rd(A_FLAG, 32'h1D, "R4 zero write no effect");
        wr(A_FLAG, 32'h05);
        rd(A_FLAG, 32'h18, "R4 clear bits 0,2");
        // R6: enable gating
        chk("R6 irq masked", {31'd0, irq}, 32'd0);
        wr(A_FEN, 32'h08);
        chk("R6 irq enabled", {31'd0, irq}, 32'd1);
        rd(A_FEN, 32'h08, "R6 enable readback");
        wr(A_FEN, 32'hFFFF_FFFF);
        rd(A_FEN, 32'h1F, "R10 reserved enable bits zero");
        // R5: same-cycle set and clear
        @(negedge clk);
        addr = A_FLAG; wr_data = 32'h01; wr_en = 1; drop_trunk = 1;
        @(negedge clk);
        wr_en = 0; drop_trunk = 0;
        rd(A_FLAG, 32'h19, "R5 set wins over clear");
        wr(A_FLAG, 32'h1F);
        chk("R6 irq drops after clear", {31'd0, irq}, 32'd0);
        // R7: code capture
        cpulse(6'h2A);
        rd(A_CODE, 32'h2A, "R7 first code captured");
        cpulse(6'h15);
        rd(A_CODE, 32'h2A, "R7 later code ignored");
        // R8: acknowledge value
        wr(A_CODE, 32'h3F);
        rd(A_CODE, 32'h2A, "R8 wrong ack ignored");
        wr(A_CODE, 32'h1FF);
        rd(A_CODE, 32'h2A, "R8 wide ack ignored");
        // R9: code mask
        wr(A_FEN, 32'h0);
        chk("R9 code irq masked", {31'd0, irq}, 32'd0);
        wr(A_CEN, 32'h15);
        chk("R9 disjoint mask", {31'd0, irq}, 32'd0);
        wr(A_CEN, 32'h02);
        chk("R9 overlapping mask", {31'd0, irq}, 32'd1);
        rd(A_CEN, 32'h02, "R9 code enable readback");
        ev(6'b000010);
        wr(A_FEN, 32'h02);
        chk("R9 both groups", {31'd0, irq}, 32'd1);
        wr(A_FEN, 32'h0);
        wr(A_CODE, 32'hFF);
        rd(A_CODE, 32'h0, "R8 ack clears");
        chk("R9 irq after ack", {31'd0, irq}, 32'd0);
        // R11: ack and capture together
        cpulse(6'h11);
        @(negedge clk);
        addr = A_CODE; wr_data = 32'hFF; wr_en = 1; code = 6'h07; code_valid = 1;
        @(negedge clk);
        wr_en = 0; code_valid = 0;
        rd(A_CODE, 32'h07, "R11 capture beats ack");
        // R10: unmapped addresses
        rd(BASE + 16'h10, 0, "R10 unmapped above");
        rd(BASE + 16'h0B, 0, "R10 unmapped below");
        rd(16'h000E, 0, "R10 wrong base");
        // R1: reset mid-run
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(A_FLAG, 0, "R1 flags after re-reset");
        rd(A_CODE, 0, "R1 code after re-reset");
        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule